// File: doc/BRIEF.md
# USB Control Endpoint Handshake Controller

This block holds the handshake decision and the firmware-visible status flags of one USB device control endpoint. A packet engine upstream presents each decoded token (SETUP, OUT or IN) for one cycle, together with an indication of whether the data packet that followed it arrived intact. On the next cycle the block answers with the handshake to return (ACK, NAK, STALL or none), or with a pulse that starts transmission of the armed IN packet.

Firmware talks to the block through a small register port. It can poll and clear four interrupt flags: setup received, OUT received, IN bank ready and NAK-sent-on-IN. It can also enable each flag onto the interrupt line and raise a stall request. A retry condition, supplied as a level from outside, takes priority over any stall. Two generic bank-control bits of the flag register have no meaning on a control endpoint and always read as zero.

Top module: `usb_cep_hs`

## Requirements
- R1: A SETUP token with an intact packet (tok_kind 2'b00, tok_ok 1) is answered with ACK (hs_code 2'b01) whatever the stall request, retry input or bank state, sets the setup flag (flag register bit 0), and leaves the OUT flag (bit 1) unchanged.
- R2: An intact SETUP clears the stall request (control register at address 2, bit 0), even if firmware writes it to 1 in the same cycle.
- R3: While retry_pend is 1, an OUT (2'b01) or IN (2'b10) token is answered with NAK (hs_code 2'b10) and never with STALL; an IN answered this way sets the NAK-on-IN flag.
- R4: With retry_pend 0 and the stall request set, an intact OUT or any IN token is answered with STALL (hs_code 2'b11).
- R5: With no retry and no stall, an intact OUT is answered with ACK and sets the OUT flag if that flag was clear; if it was already set the OUT gets NAK and no flag changes.
- R6: The IN-ready flag (bit 2) is 1 after reset. Firmware clearing it arms a packet; the next IN token with no retry and no stall pulses in_tx for one cycle, returns hs_code 2'b00, sets IN-ready again and disarms.
- R7: An IN token with nothing armed, no retry and no stall gets NAK and sets the NAK-on-IN flag (bit 3).
- R8: Writing the flag register (address 0) clears each flag whose data bit is 0 and leaves those written 1 untouched; a hardware set in the same cycle wins over the clear.
- R9: Bits 5 and 4 of the flag register always read 0, whatever is written to them.
- R10: irq equals the OR of every flag that is set and whose enable bit (same position, address 1) is set.
- R11: A SETUP or OUT token whose packet is not intact, and any token of kind 2'b11, produces no handshake and changes no state.
- R12: hs_code and in_tx show the response in the cycle after the token and return to 2'b00 / 0 in the following cycle when no token follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | A decoded token is present this cycle |
| tok_kind | input | 2 | 00 SETUP, 01 OUT, 10 IN, 11 reserved |
| tok_ok | input | 1 | Data packet after a SETUP or OUT token arrived intact |
| retry_pend | input | 1 | Retry condition pending |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 flags, 1 enables, 2 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |
| in_tx | output | 1 | One-cycle pulse: send the armed IN packet |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach from the ports are an IN token that finds a packet already armed, and a firmware clear that lands in the same cycle as a hardware set of the same flag. Arming needs a write that clears IN-ready followed by an IN token with neither retry nor stall active, so the random stimulus writes the flag register often with random data and weights IN tokens heavily. Directed steps then force the collisions explicitly: an OUT token against a clear of the OUT flag, and a SETUP against a write that sets the stall request.

// File: rtl/usb_cep_pkg.sv
package usb_cep_pkg;

   typedef enum logic [1:0] {
      TOK_SETUP = 2'd0,
      TOK_OUT   = 2'd1,
      TOK_IN    = 2'd2,
      TOK_RSVD  = 2'd3
   } tok_e;

   typedef enum logic [1:0] {
      HS_NONE  = 2'd0,
      HS_ACK   = 2'd1,
      HS_NAK   = 2'd2,
      HS_STALL = 2'd3
   } hs_e;

   localparam int NFLAGS  = 4;
   localparam int F_SETUP = 0;
   localparam int F_OUT   = 1;
   localparam int F_INRDY = 2;
   localparam int F_NAKIN = 3;
   localparam int NZERO   = 2;   // bank-control bits above the flags, always 0

   typedef struct packed {
      hs_e               hs;
      logic              tx;
      logic [NFLAGS-1:0] hw_set;
      logic              clr_stall;
      logic              disarm;
   } decision_t;

endpackage

// File: rtl/usb_cep_flag.sv
module usb_cep_flag #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic fw_clr,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= RST_VAL;
      else if (hw_set) q <= 1'b1;
      else if (fw_clr) q <= 1'b0;
   end

   p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set && fw_clr) |=> q)
      else $error("flag lost a hardware set against a firmware clear");

endmodule

// File: rtl/usb_cep_decide.sv
module usb_cep_decide
   import usb_cep_pkg::*;
(
   input  logic      tok_valid,
   input  logic [1:0] tok_kind,
   input  logic      tok_ok,
   input  logic      retry,
   input  logic      stall,
   input  logic      out_busy,
   input  logic      armed,
   output decision_t dec
);

   always_comb begin
      dec = '{hs: HS_NONE, tx: 1'b0, hw_set: '0, clr_stall: 1'b0, disarm: 1'b0};
      if (tok_valid) begin
         unique case (tok_kind)
            TOK_SETUP: begin
               if (tok_ok) begin
                  dec.hs              = HS_ACK;
                  dec.hw_set[F_SETUP] = 1'b1;
                  dec.clr_stall       = 1'b1;
               end
            end
            TOK_OUT: begin
               if (tok_ok) begin
                  if (retry)         dec.hs = HS_NAK;
                  else if (stall)    dec.hs = HS_STALL;
                  else if (out_busy) dec.hs = HS_NAK;
                  else begin
                     dec.hs            = HS_ACK;
                     dec.hw_set[F_OUT] = 1'b1;
                  end
               end
            end
            TOK_IN: begin
               if (retry) begin
                  dec.hs              = HS_NAK;
                  dec.hw_set[F_NAKIN] = 1'b1;
               end else if (stall) begin
                  dec.hs = HS_STALL;
               end else if (armed) begin
                  dec.tx              = 1'b1;
                  dec.hw_set[F_INRDY] = 1'b1;
                  dec.disarm          = 1'b1;
               end else begin
                  dec.hs              = HS_NAK;
                  dec.hw_set[F_NAKIN] = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/usb_cep_regif.sv
module usb_cep_regif
   import usb_cep_pkg::*;
#(
   parameter int              ADDR_W     = 2,
   parameter int              DATA_W     = 8,
   parameter logic [ADDR_W-1:0] ADDR_FLAGS = '0,
   parameter logic [ADDR_W-1:0] ADDR_EN    = 'd1,
   parameter logic [ADDR_W-1:0] ADDR_CTRL  = 'd2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NFLAGS-1:0] flags,
   input  logic [NFLAGS-1:0] en,
   input  logic              stall,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (addr == ADDR_FLAGS) begin
         rdata[NFLAGS-1:0]            = flags;
         rdata[NFLAGS+NZERO-1:NFLAGS] = '0;
      end else if (addr == ADDR_EN) begin
         rdata[NFLAGS-1:0] = en;
      end else if (addr == ADDR_CTRL) begin
         rdata[0] = stall;
      end
   end

endmodule

// File: rtl/usb_cep_hs.sv
module usb_cep_hs
   import usb_cep_pkg::*;
#(
   parameter int              ADDR_W     = 2,
   parameter int              DATA_W     = 8,
   parameter logic [ADDR_W-1:0] ADDR_FLAGS = '0,
   parameter logic [ADDR_W-1:0] ADDR_EN    = 'd1,
   parameter logic [ADDR_W-1:0] ADDR_CTRL  = 'd2,
   parameter bit              IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid,
   input  logic [1:0]        tok_kind,
   input  logic              tok_ok,
   input  logic              retry_pend,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [1:0]        hs_code,
   output logic              in_tx,
   output logic              irq
);

   localparam int          MIN_DATA_W = NFLAGS + NZERO;
   localparam logic [NFLAGS-1:0] FLAG_RST = NFLAGS'(1) << F_INRDY;

   if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
      $error("DATA_W too small for the flag register");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W must hold three register addresses");
   end
   if (ADDR_FLAGS == ADDR_EN || ADDR_FLAGS == ADDR_CTRL || ADDR_EN == ADDR_CTRL) begin : g_bad_map
      $error("register addresses must differ");
   end

   decision_t         dec;
   logic [NFLAGS-1:0] flag_q;
   logic [NFLAGS-1:0] fw_clr;
   logic [NFLAGS-1:0] en_q;
   logic              stall_q;
   logic              armed_q;
   logic [1:0]        hs_q;
   logic              tx_q;
   logic              wr_flags, wr_en, wr_ctrl;

   assign wr_flags = reg_wr && (reg_addr == ADDR_FLAGS);
   assign wr_en    = reg_wr && (reg_addr == ADDR_EN);
   assign wr_ctrl  = reg_wr && (reg_addr == ADDR_CTRL);

   usb_cep_decide u_decide (
      .tok_valid (tok_valid),
      .tok_kind  (tok_kind),
      .tok_ok    (tok_ok),
      .retry     (retry_pend),
      .stall     (stall_q),
      .out_busy  (flag_q[F_OUT]),
      .armed     (armed_q),
      .dec       (dec)
   );

   for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
      assign fw_clr[i] = wr_flags && !reg_wdata[i];
      usb_cep_flag #(.RST_VAL(FLAG_RST[i])) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .hw_set (dec.hw_set[i]),
         .fw_clr (fw_clr[i]),
         .q      (flag_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= '0;
         stall_q <= 1'b0;
         armed_q <= 1'b0;
         hs_q    <= HS_NONE;
         tx_q    <= 1'b0;
      end else begin
         hs_q <= dec.hs;
         tx_q <= dec.tx;
         if (wr_en) en_q <= reg_wdata[NFLAGS-1:0];
         if (dec.clr_stall)  stall_q <= 1'b0;
         else if (wr_ctrl)   stall_q <= reg_wdata[0];
         if (dec.disarm)
            armed_q <= 1'b0;
         else if (fw_clr[F_INRDY] && flag_q[F_INRDY] && !dec.hw_set[F_INRDY])
            armed_q <= 1'b1;
      end
   end

   assign hs_code = hs_q;
   assign in_tx   = tx_q;

   usb_cep_regif #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .ADDR_FLAGS (ADDR_FLAGS),
      .ADDR_EN    (ADDR_EN),
      .ADDR_CTRL  (ADDR_CTRL)
   ) u_regif (
      .addr  (reg_addr),
      .flags (flag_q),
      .en    (en_q),
      .stall (stall_q),
      .rdata (reg_rdata)
   );

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(flag_q & en_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(flag_q & en_q);
   end

   p_setup_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind == TOK_SETUP && tok_ok) |=> hs_code == HS_ACK)
      else $error("SETUP not acknowledged");

   p_setup_out_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind == TOK_SETUP && tok_ok && !wr_flags) |=> $stable(flag_q[F_OUT]))
      else $error("SETUP disturbed the OUT flag");

   p_setup_unstall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind == TOK_SETUP && tok_ok) |=> !stall_q)
      else $error("stall request survived a SETUP");

   p_retry_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      retry_pend |=> hs_code != HS_STALL)
      else $error("STALL sent while retry pending");

   p_stall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hs_code == HS_STALL |-> ($past(stall_q) && !$past(retry_pend)))
      else $error("STALL without a stall request");

   p_nak_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_kind == TOK_IN) |=> (hs_code != HS_NAK || flag_q[F_NAKIN]))
      else $error("NAK on IN left the NAK flag clear");

   p_tx_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_tx |-> (flag_q[F_INRDY] && !armed_q && hs_code == HS_NONE))
      else $error("IN packet sent without rearming the bank flag");

endmodule

// File: tb/sim_usb_cep_hs.sv
module sim_usb_cep_hs;

   localparam int CLK_PERIOD = 10;
   localparam int N_RAND     = 4000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tok_valid;
   logic [1:0] tok_kind;
   logic       tok_ok;
   logic       retry_pend;
   logic       reg_wr;
   logic [1:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic [1:0] hs_code;
   logic       in_tx;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [3:0] m_fl, m_en;
   logic       m_st, m_arm;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_cep_hs u0 (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
      .tok_ok(tok_ok), .retry_pend(retry_pend), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hs_code(hs_code), .in_tx(in_tx), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0:    return {4'b0, m_fl};
         2'd1:    return {4'b0, m_en};
         2'd2:    return {7'b0, m_st};
         default: return 8'h00;
      endcase
   endfunction

   task automatic step(input logic tv, input logic [1:0] tk, input logic tok,
                       input logic rt, input logic wr, input logic [1:0] ad,
                       input logic [7:0] wd);
      logic [1:0] ehs;
      logic       etx, clrst, disarm;
      logic [3:0] set, clr;
      string      tag;
      @(negedge clk);
      tok_valid = tv; tok_kind = tk; tok_ok = tok; retry_pend = rt;
      reg_wr = wr; reg_addr = ad; reg_wdata = wd;
      ehs = 2'd0; etx = 1'b0; set = '0; clrst = 1'b0; disarm = 1'b0;
      tag = tv ? "R11" : "R12";
      if (tv) begin
         case (tk)
            2'd0: if (tok) begin ehs = 2'd1; set[0] = 1'b1; clrst = 1'b1; tag = "R1"; end
            2'd1: if (tok) begin
               if (rt)           begin ehs = 2'd2; tag = "R3"; end
               else if (m_st)    begin ehs = 2'd3; tag = "R4"; end
               else if (m_fl[1]) begin ehs = 2'd2; tag = "R5"; end
               else              begin ehs = 2'd1; set[1] = 1'b1; tag = "R5"; end
            end
            2'd2: begin
               if (rt)         begin ehs = 2'd2; set[3] = 1'b1; tag = "R3"; end
               else if (m_st)  begin ehs = 2'd3; tag = "R4"; end
               else if (m_arm) begin etx = 1'b1; set[2] = 1'b1; disarm = 1'b1; tag = "R6"; end
               else            begin ehs = 2'd2; set[3] = 1'b1; tag = "R7"; end
            end
            default: ;
         endcase
      end
      clr = (wr && ad == 2'd0) ? ~wd[3:0] : 4'b0;
      @(posedge clk);
      #1;
      if (disarm) m_arm = 1'b0;
      else if (clr[2] && m_fl[2] && !set[2]) m_arm = 1'b1;
      m_fl = (m_fl & ~clr) | set;
      if (wr && ad == 2'd1) m_en = wd[3:0];
      if (clrst) m_st = 1'b0;
      else if (wr && ad == 2'd2) m_st = wd[0];
      chk(hs_code == ehs, tag, {6'b0, hs_code}, {6'b0, ehs});
      chk(in_tx == etx, "R6", {7'b0, in_tx}, {7'b0, etx});
      chk(irq == |(m_fl & m_en), "R10", {7'b0, irq}, {7'b0, |(m_fl & m_en)});
      chk(reg_rdata == exp_read(ad), (ad == 2'd0) ? "R8" : "R2", reg_rdata, exp_read(ad));
   endtask

   task automatic idle();
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int seed;
      seed = 32'h5eed_0042;
      void'($urandom(seed));
      rst_n = 1'b0; tok_valid = 1'b0; tok_kind = 2'd0; tok_ok = 1'b0;
      retry_pend = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
      m_fl = 4'b0100; m_en = 4'b0; m_st = 1'b0; m_arm = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // reset state: only IN-ready set (R6), no handshake, no interrupt
      chk(reg_rdata == 8'h04, "R6", reg_rdata, 8'h04);
      chk(hs_code == 2'd0, "R12", {6'b0, hs_code}, 8'h00);
      chk(irq == 1'b0, "R10", {7'b0, irq}, 8'h00);

      // R5: OUT accepted, then NAKed while bank busy
      step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
      step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);
      // R12: response lasts one cycle
      idle();
      chk(hs_code == 2'd0, "R12", {6'b0, hs_code}, 8'h00);
      // R8: clear OUT flag; first with the hardware-set race is not possible while busy,
      // so clear, then collide a new OUT with another clear
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 8'hFD);
      step(1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 8'hFD);
      chk(reg_rdata[1] == 1'b1, "R8", reg_rdata, 8'h02);
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 8'hFD);
      // R4 / R3: stall request, OUT stalled, retry overrides
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd2, 8'h01);
      step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd2, 8'h00);
      step(1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 8'h00);
      step(1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 2'd2, 8'h00);
      // R1 / R2: SETUP acked under stall and retry, clears stall against a same-cycle set
      step(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 2'd2, 8'h01);
      chk(reg_rdata[0] == 1'b0, "R2", reg_rdata, 8'h00);
      // R6: arm by clearing IN-ready, IN sends it
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 8'hFB);
      step(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
      chk(reg_rdata[2] == 1'b1, "R6", reg_rdata, 8'h04);
      // R7: nothing armed, IN NAKed
      step(1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
      chk(reg_rdata[3] == 1'b1, "R7", reg_rdata, 8'h08);
      // R9: bank-control bits written as 1 read 0
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 8'hFF);
      chk(reg_rdata[5:4] == 2'b00, "R9", reg_rdata, {2'b0, reg_rdata[3:0]});
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h30);
      chk(reg_rdata == 8'h00, "R9", reg_rdata, 8'h00);
      // R10: enable OUT flag, OUT raises irq
      step(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 8'h02);
      step(1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 8'h00);
      chk(irq == 1'b1, "R10", {7'b0, irq}, 8'h01);
      // R11: corrupt SETUP/OUT and reserved token do nothing
      step(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
      step(1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
      step(1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00);

      for (int n = 0; n < N_RAND; n++) begin
         logic       tv, tok, rt, wr;
         logic [1:0] tk, ad;
         logic [7:0] wd;
         tv  = ($urandom % 3) != 0;
         tk  = ($urandom % 8 < 4) ? 2'd2 : 2'($urandom % 4);
         tok = ($urandom % 8) != 0;
         rt  = ($urandom % 10) == 0;
         wr  = ($urandom % 3) == 0;
         ad  = 2'($urandom % 4);
         wd  = 8'($urandom);
         if (ad == 2'd2 && ($urandom % 2) == 0) wd[0] = 1'b0;
         step(tv, tk, tok, rt, wr, ad, wd);
      end
      idle();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule